// File: doc/BRIEF.md
# Deferred Accelerator Result Write-Back

This block sits between a processor core, a small accelerator that retires short instruction pairs in parallel with the core, and a register file that has a single write port. The accelerator hands over one result, its destination register and the address of the pair. If the pair ends in a branch, the accelerator also hands over a return address for the link register. The core keeps full use of the write port. The block parks each accelerator value and writes it in the first cycle when the core leaves the port unused. Until that write happens, the block forwards the parked value to any read of its register, so software sees the same architectural state either way.

The block contains the register file and its read ports, a small retirement controller, and a forwarding stage. The controller walks through idle, data-retire, link-retire and done phases. While a value is still parked it accepts no new invocation. It raises a stall output so that the source holds a second, back-to-back invocation until the earlier values have drained.

Top module: `deferred_wb`

## Requirements
- R1: After reset every register reads as zero on both read ports and the stall output is low.
- R2: The register file takes at most one write per cycle. A core write (core_we high) always lands at that clock edge. An accelerator value is written only in a cycle where core_we is low.
- R3: An invocation is accepted when acc_valid is high and stall is low. At that edge the block captures the result and destination. The result reaches the register file at the first later edge where core_we is low, unless R5 cancels it.
- R4: While a value is parked, a read of its register on either read port returns the parked value. All other reads return register-file contents. A core write to the same register in the acceptance cycle counts as older than the accelerator result.
- R5: A core write to a parked register in a cycle after acceptance is newer than the parked value. That parked write is dropped, and later reads return the core's value.
- R6: For a pair with acc_branch high, the return address acc_pc + PAIR_DEPTH*INSTR_BYTES (4 by default) goes to register 14. It is written at the first free edge after the data result has retired or been dropped. Until then it is forwarded to reads of register 14. A core write to register 14 after acceptance cancels it.
- R7: For a branching pair whose destination is register 14, the return address supersedes the data result. Only the return address is written.
- R8: stall is high exactly in the cycles where acc_valid is high while a data or link value is still parked. A non-branching invocation occupies the block until one retiring edge has passed; a branching one needs two. When the core is idle, back-to-back invocations therefore see one stall cycle (non-branching) or two (branching).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_we | input | 1 | Core write enable for the register file |
| core_waddr | input | AW (4) | Core write register index |
| core_wdata | input | XLEN (32) | Core write data |
| acc_valid | input | 1 | Accelerator invocation present |
| acc_dst | input | AW (4) | Destination register of the pair result |
| acc_data | input | XLEN (32) | Pair result value |
| acc_branch | input | 1 | Pair ends in a branch; a return address must be written |
| acc_pc | input | XLEN (32) | Address of the first instruction of the pair |
| rd_addr | input | NRD×AW (2×4) | Read port register indices |
| rd_data | output | NRD×XLEN (2×32) | Read port data, with parked values forwarded |
| stall | output | 1 | Invocation must be held; the earlier values are still draining |

## Verification
The assertions assume that the source keeps acc_valid and its fields steady while stall is high, and that the core never claims the write port for a parked value by any path other than core_we. The stimulus follows both rules. Each cycle the bench samples stall before the edge, and when stall was high it re-drives the same invocation. Random cycles aim reads at the parked destination and at register 14, mix free and busy write-port cycles, and include core writes that collide with parked registers. A bench-side architectural model therefore covers cancellation, link supersession and slot reuse.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_LINK = 2'd2,
    PH_DONE = 2'd3
  } wb_phase_e;

  // byte distance from the pair start to the instruction after it
  function automatic int unsigned pair_span(input int unsigned depth, input int unsigned ibytes);
    return depth * ibytes;
  endfunction

  // a parked value hides register-file contents for a matching read
  function automatic logic fwd_hit(input logic pend, input logic [7:0] want, input logic [7:0] have);
    return pend && (want == have);
  endfunction

endpackage

// File: rtl/wb_regfile.sv
module wb_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [XLEN-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata
);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = regs[raddr[p]];
  end

endmodule

// File: rtl/wb_pend_ctrl.sv
module wb_pend_ctrl
  import dwb_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int AW       = 4,
  parameter int LINK_IDX = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_we,
  input  logic [AW-1:0]   core_waddr,
  input  logic            acc_valid,
  input  logic [AW-1:0]   acc_dst,
  input  logic [XLEN-1:0] acc_data,
  input  logic            acc_branch,
  input  logic [XLEN-1:0] acc_link,
  output logic            stall,
  output logic            accept,
  output logic            need_upd,
  output logic [AW-1:0]   d_reg,
  output logic [XLEN-1:0] d_val,
  output logic            link_upd,
  output logic [XLEN-1:0] l_val,
  output logic            commit_data,
  output logic            commit_link,
  output wb_phase_e       phase
);

  localparam logic [AW-1:0] LINK = AW'(LINK_IDX);

  logic busy, slot_free, d_hit, l_hit, drop_data, drop_link, data_done, keep_data;

  assign busy      = (phase == PH_DATA) || (phase == PH_LINK);
  assign accept    = acc_valid && !busy;
  assign stall     = acc_valid && busy;
  assign slot_free = !core_we;
  assign d_hit     = core_we && (core_waddr == d_reg);
  assign l_hit     = core_we && (core_waddr == LINK);

  assign commit_data = (phase == PH_DATA) && need_upd && slot_free;
  assign drop_data   = (phase == PH_DATA) && need_upd && d_hit;
  assign data_done   = commit_data || drop_data;
  assign commit_link = (phase == PH_LINK) && link_upd && slot_free;
  assign drop_link   = link_upd && l_hit;

  // a branching pair that targets the link register keeps only the return address
  assign keep_data = !(acc_branch && (acc_dst == LINK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      need_upd <= 1'b0;
      link_upd <= 1'b0;
      d_reg    <= '0;
      d_val    <= '0;
      l_val    <= '0;
    end else if (accept) begin
      d_reg    <= acc_dst;
      d_val    <= acc_data;
      l_val    <= acc_link;
      need_upd <= keep_data;
      link_upd <= acc_branch;
      phase    <= keep_data ? PH_DATA : PH_LINK;
    end else begin
      unique case (phase)
        PH_IDLE: phase <= PH_IDLE;
        PH_DATA: begin
          if (drop_link) link_upd <= 1'b0;
          if (data_done) begin
            need_upd <= 1'b0;
            phase    <= (link_upd && !drop_link) ? PH_LINK : PH_DONE;
          end
        end
        PH_LINK: begin
          if (commit_link || drop_link) begin
            link_upd <= 1'b0;
            phase    <= PH_DONE;
          end
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wb_fwd.sv
module wb_fwd
  import dwb_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int AW       = 4,
  parameter int NRD      = 2,
  parameter int LINK_IDX = 14
) (
  input  logic [NRD-1:0][AW-1:0]   raddr,
  input  logic [NRD-1:0][XLEN-1:0] rf_rdata,
  input  logic                     need_upd,
  input  logic [AW-1:0]            d_reg,
  input  logic [XLEN-1:0]          d_val,
  input  logic                     link_upd,
  input  logic [XLEN-1:0]          l_val,
  output logic [NRD-1:0][XLEN-1:0] rdata
);

  localparam logic [7:0] LINK8 = 8'(LINK_IDX);

  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic [7:0] want;
    assign want = 8'(raddr[p]);
    always_comb begin
      if (fwd_hit(link_upd, want, LINK8))            rdata[p] = l_val;
      else if (fwd_hit(need_upd, want, 8'(d_reg)))   rdata[p] = d_val;
      else                                           rdata[p] = rf_rdata[p];
    end
  end

endmodule

// File: rtl/deferred_wb.sv
module deferred_wb
  import dwb_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NREG        = 16,
  parameter int NRD         = 2,
  parameter int LINK_IDX    = 14,
  parameter int PAIR_DEPTH  = 2,
  parameter int INSTR_BYTES = 2,
  localparam int AW         = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     core_we,
  input  logic [AW-1:0]            core_waddr,
  input  logic [XLEN-1:0]          core_wdata,
  input  logic                     acc_valid,
  input  logic [AW-1:0]            acc_dst,
  input  logic [XLEN-1:0]          acc_data,
  input  logic                     acc_branch,
  input  logic [XLEN-1:0]          acc_pc,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][XLEN-1:0] rd_data,
  output logic                     stall
);

  localparam logic [AW-1:0]   LINK = AW'(LINK_IDX);
  localparam logic [XLEN-1:0] SPAN = XLEN'(pair_span(PAIR_DEPTH, INSTR_BYTES));

  logic            accept, need_upd, link_upd, commit_data, commit_link;
  logic [AW-1:0]   d_reg;
  logic [XLEN-1:0] d_val, l_val, acc_link;
  wb_phase_e       phase;

  logic                     rf_we;
  logic [AW-1:0]            rf_waddr;
  logic [XLEN-1:0]          rf_wdata;
  logic [NRD-1:0][XLEN-1:0] rf_rdata;

  assign acc_link = acc_pc + SPAN;

  wb_pend_ctrl #(.XLEN(XLEN), .AW(AW), .LINK_IDX(LINK_IDX)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .core_we(core_we), .core_waddr(core_waddr),
    .acc_valid(acc_valid), .acc_dst(acc_dst), .acc_data(acc_data),
    .acc_branch(acc_branch), .acc_link(acc_link),
    .stall(stall), .accept(accept),
    .need_upd(need_upd), .d_reg(d_reg), .d_val(d_val),
    .link_upd(link_upd), .l_val(l_val),
    .commit_data(commit_data), .commit_link(commit_link),
    .phase(phase)
  );

  // the core owns the port; parked values only use idle cycles
  always_comb begin
    rf_we    = core_we || commit_data || commit_link;
    rf_waddr = core_waddr;
    rf_wdata = core_wdata;
    if (!core_we) begin
      rf_waddr = commit_link ? LINK  : d_reg;
      rf_wdata = commit_link ? l_val : d_val;
    end
  end

  wb_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rd_addr), .rdata(rf_rdata)
  );

  wb_fwd #(.XLEN(XLEN), .AW(AW), .NRD(NRD), .LINK_IDX(LINK_IDX)) u_fwd (
    .raddr(rd_addr), .rf_rdata(rf_rdata),
    .need_upd(need_upd), .d_reg(d_reg), .d_val(d_val),
    .link_upd(link_upd), .l_val(l_val),
    .rdata(rd_data)
  );

endmodule

// File: rtl/dwb_chk.sv
module dwb_chk #(
  parameter int AW       = 4,
  parameter int LINK_IDX = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_we,
  input logic [AW-1:0] core_waddr,
  input logic          acc_valid,
  input logic          stall,
  input logic          accept,
  input logic          need_upd,
  input logic          link_upd,
  input logic [AW-1:0] d_reg,
  input logic          commit_data,
  input logic          commit_link,
  input logic          rf_we,
  input logic [AW-1:0] rf_waddr
);

  AST_PORT_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_data || commit_link) |-> !core_we); // R2
  AST_SINGLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_data && commit_link)); // R2
  AST_CORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    core_we |-> (rf_we && rf_waddr == core_waddr)); // R2
  AST_ACCEPT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (need_upd || link_upd)); // R3
  AST_FREE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (need_upd && !core_we) |=> !need_upd); // R3
  AST_NEWER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (need_upd && core_we && core_waddr == d_reg) |=> !need_upd); // R5
  AST_LINK_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    commit_link |-> (rf_waddr == AW'(LINK_IDX))); // R6
  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    commit_link |-> !need_upd); // R6
  AST_STALL_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (acc_valid && (need_upd || link_upd))); // R8
  AST_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && accept)); // R8

endmodule

bind deferred_wb dwb_chk #(.AW(AW), .LINK_IDX(LINK_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .core_we(core_we), .core_waddr(core_waddr),
  .acc_valid(acc_valid), .stall(stall), .accept(accept),
  .need_upd(need_upd), .link_upd(link_upd), .d_reg(d_reg),
  .commit_data(commit_data), .commit_link(commit_link),
  .rf_we(rf_we), .rf_waddr(rf_waddr)
);

// File: tb/sim_deferred_wb.sv
module sim_deferred_wb;
  localparam int XLEN = 32, NREG = 16, NRD = 2, AW = 4, LINK = 14, SPAN = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, core_we, acc_valid, acc_branch, stall;
  logic [AW-1:0] core_waddr, acc_dst;
  logic [XLEN-1:0] core_wdata, acc_data, acc_pc;
  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][XLEN-1:0] rd_data;

  deferred_wb u0 (
    .clk(clk), .rst_n(rst_n), .core_we(core_we), .core_waddr(core_waddr),
    .core_wdata(core_wdata), .acc_valid(acc_valid), .acc_dst(acc_dst),
    .acc_data(acc_data), .acc_branch(acc_branch), .acc_pc(acc_pc),
    .rd_addr(rd_addr), .rd_data(rd_data), .stall(stall)
  );

  int checks = 0, fails = 0, stall_seen = 0;
  bit finished = 0, last_stall = 0;
  logic [XLEN-1:0] arch [NREG];
  bit pd = 0, pl = 0;
  logic [AW-1:0] pdr = '0;

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit we, input int wa, input logic [XLEN-1:0] wd,
                       input bit av, input int dst, input logic [XLEN-1:0] dv,
                       input bit br, input logic [XLEN-1:0] pc, input int r0, input int r1);
    core_we = we; core_waddr = AW'(wa); core_wdata = wd;
    acc_valid = av; acc_dst = AW'(dst); acc_data = dv; acc_branch = br; acc_pc = pc;
    rd_addr[0] = AW'(r0); rd_addr[1] = AW'(r1);
  endtask

  // sample before the edge, then advance the architectural model
  task automatic step(input string req);
    bit busy, ok;
    #2;
    busy = pd || pl;
    ok = acc_valid && !busy;
    for (int p = 0; p < NRD; p++) chk(req, rd_data[p], arch[rd_addr[p]]);
    chk("R8", {31'b0, stall}, {31'b0, acc_valid && busy});
    last_stall = stall;
    if (stall) stall_seen++;
    if (pd) begin
      if (core_we && core_waddr == AW'(LINK)) pl = 0;
      if (!core_we || core_waddr == pdr) pd = 0;
    end else if (pl) begin
      if (!core_we || core_waddr == AW'(LINK)) pl = 0;
    end
    if (core_we) arch[core_waddr] = core_wdata;
    if (ok) begin
      arch[acc_dst] = acc_data;
      if (acc_branch) arch[LINK] = acc_pc + SPAN;
      pd = !(acc_branch && acc_dst == AW'(LINK));
      pl = acc_branch;
      pdr = acc_dst;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input int r0, input int r1, input string req);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 0, 0, 0, 0, 0, 0, r0, r1);
      step(req);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    summary();
  end

  initial begin
    for (int i = 0; i < NREG; i++) arch[i] = '0;
    rst_n = 0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state on every register
    for (int i = 0; i < NREG; i += 2) begin
      drive(0, 0, 0, 0, 0, 0, 0, 0, i, i + 1);
      step("R1");
    end

    // R3: parked while the core holds the port, then retired
    drive(1, 2, 32'h22, 1, 5, 32'hA5A5_0005, 0, 0, 5, 2); step("R3");
    for (int i = 0; i < 3; i++) begin
      drive(1, 2, 32'h100 + i, 0, 0, 0, 0, 0, 5, 2); step("R2");
    end
    idle(1, 5, 2, "R3");
    drive(0, 0, 0, 1, 6, 32'h0606, 0, 0, 5, 6); step("R3");
    idle(2, 5, 6, "R3");

    // R4: same-cycle core write is older than the pair result
    drive(1, 7, 32'hC0C0, 1, 7, 32'hACAC, 0, 0, 7, 1); step("R4");
    idle(2, 7, 1, "R4");

    // R5: later core write supersedes the parked value
    drive(1, 3, 32'h3, 1, 9, 32'h9999, 0, 0, 9, 3); step("R5");
    drive(1, 9, 32'h1234, 0, 0, 0, 0, 0, 9, 3); step("R5");
    idle(3, 9, 3, "R5");
    chk("R5", rd_data[0], 32'h1234);

    // R6: branching pair, data then link with a busy core in between
    drive(1, 1, 32'h11, 1, 3, 32'h3333, 1, 32'h100, 3, 14); step("R6");
    drive(1, 1, 32'h12, 0, 0, 0, 0, 0, 3, 14); step("R6");
    idle(1, 3, 14, "R6");
    drive(1, 4, 32'h44, 0, 0, 0, 0, 0, 3, 14); step("R6");
    idle(2, 3, 14, "R6");
    chk("R6", rd_data[1], 32'h104);
    // R6: core write to r14 cancels a parked return address
    drive(0, 0, 0, 1, 8, 32'h8888, 1, 32'h200, 8, 14); step("R6");
    drive(1, 14, 32'hEEEE, 0, 0, 0, 0, 0, 8, 14); step("R6");
    idle(3, 8, 14, "R6");
    chk("R6", rd_data[1], 32'hEEEE);

    // R7: branching pair aimed at r14 keeps only the return address
    drive(0, 0, 0, 1, 14, 32'hDEAD, 1, 32'h300, 14, 0); step("R7");
    idle(3, 14, 0, "R7");
    chk("R7", rd_data[0], 32'h304);

    // R8: back-to-back invocations with an idle core
    stall_seen = 0;
    drive(0, 0, 0, 1, 4, 32'h4444, 0, 0, 4, 10); step("R8");
    drive(0, 0, 0, 1, 10, 32'hAAAA, 0, 0, 4, 10); step("R8");
    while (last_stall) step("R8");
    idle(2, 4, 10, "R8");
    chk("R8", stall_seen, 1);
    stall_seen = 0;
    drive(0, 0, 0, 1, 11, 32'hBBBB, 1, 32'h400, 11, 14); step("R8");
    drive(0, 0, 0, 1, 12, 32'hCCCC, 0, 0, 12, 14); step("R8");
    while (last_stall) step("R8");
    idle(2, 12, 14, "R8");
    chk("R8", stall_seen, 2);

    // R4: random sweep with hold-while-stalled
    for (int n = 0; n < 4000; n++) begin
      bit we, av, br;
      int wa, dst, r0, r1;
      we = ($urandom % 3) != 0;
      wa = ($urandom % 4 == 0) ? int'(pdr) : (($urandom % 5 == 0) ? LINK : int'($urandom % NREG));
      r0 = ($urandom % 2 == 0) ? int'(pdr) : int'($urandom % NREG);
      r1 = ($urandom % 2 == 0) ? LINK : int'($urandom % NREG);
      if (last_stall) begin
        core_we = we; core_waddr = AW'(wa); core_wdata = $urandom;
        rd_addr[0] = AW'(r0); rd_addr[1] = AW'(r1);
      end else begin
        av = ($urandom % 3) == 0;
        br = ($urandom % 3) == 0;
        dst = ($urandom % 6 == 0) ? LINK : int'($urandom % NREG);
        drive(we, wa, $urandom, av, dst, $urandom, br, $urandom & 32'hFFFF_FFFE, r0, r1);
      end
      step("R4");
    end
    idle(4, 0, 1, "R3");
    for (int i = 0; i < NREG; i += 2) begin
      drive(0, 0, 0, 0, 0, 0, 0, 0, i, i + 1);
      step("R3");
    end
    summary();
  end
endmodule